// File: doc/BRIEF.md
# Sixteen-bit Arithmetic/Logic Unit with Set-on-Less

This block is the combinational arithmetic/logic unit of a small register-machine processor. It takes two operands and a three-bit operation code and returns a result of the same width plus a one-bit flag that is high when the result is all zeros. Six operations are supported:

- add
- subtract
- bitwise AND
- bitwise OR
- one-hot decode of the first operand
- an unsigned set-on-less that returns exactly 0 or 1

The branch logic of the processor resolves equal / not-equal branches by asking the unit to subtract two register values and then looking at the zero flag.

Inside, a small control decoder turns the operation code into one-hot operation strobes. A datapath uses those strobes to steer a single shared adder and a result selector. The data width is a parameter with a default of 16, and it must be a power of two.

Top module: `alu16`

## Requirements
- R1: Code 000 returns opA + opB modulo 2^dataW, with no carry output.
- R2: Code 001 returns opA - opB modulo 2^dataW (for example 0 - 1 gives all ones).
- R3: Code 010 returns the bitwise AND of the operands, and code 011 returns their bitwise OR.
- R4: Code 100 returns a word in which exactly one bit is set. The index of that bit is taken from the low log2(dataW) bits of opA (the low 4 bits at the default width), and opB is ignored.
- R5: Code 101 returns 1 when opA is less than opB, compared as unsigned numbers, and returns 0 otherwise. All bits above bit 0 are always zero.
- R6: Codes 110 and 111 return a zero result, whatever the operands are.
- R7: isZero is 1 exactly when every bit of result is 0, for every operation code.
- R8: When code 001 is applied to two equal operands, isZero is 1. When it is applied to two unequal operands, isZero is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | dataW | First operand; also the index source for decode |
| opB | input | dataW | Second operand |
| opCode | input | 3 | Operation select |
| result | output | dataW | Operation result |
| isZero | output | 1 | High when result is all zeros |

## Verification
The bench builds the unit twice:

- **dataW = 4.** Every operation code is crossed with every operand pair, which makes the sweep fully exhaustive. It reaches every decode index, both sides of every unsigned comparison, and every wrap-around of the adder.
- **dataW = 16 (the default).** This instance runs directed corner operands (0, 1, all ones, the top bit alone, equal pairs) and a few thousand random pairs. These show that the logic scales to the full carry chain and to the 4-bit decode index.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int OpCodeW = 3;

  localparam logic [OpCodeW-1:0] OpAdd = 3'b000;
  localparam logic [OpCodeW-1:0] OpSub = 3'b001;
  localparam logic [OpCodeW-1:0] OpAnd = 3'b010;
  localparam logic [OpCodeW-1:0] OpOr  = 3'b011;
  localparam logic [OpCodeW-1:0] OpDec = 3'b100;
  localparam logic [OpCodeW-1:0] OpSlt = 3'b101;

  typedef struct packed {
    logic doAdd;
    logic doSub;
    logic doAnd;
    logic doOr;
    logic doDec;
    logic doSlt;
  } aluStrobe_t;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
(
  input  logic [OpCodeW-1:0] opCode,
  output aluStrobe_t         strb
);

  always_comb begin
    strb = '0;
    unique case (opCode)
      OpAdd:   strb.doAdd = 1'b1;
      OpSub:   strb.doSub = 1'b1;
      OpAnd:   strb.doAnd = 1'b1;
      OpOr:    strb.doOr  = 1'b1;
      OpDec:   strb.doDec = 1'b1;
      OpSlt:   strb.doSlt = 1'b1;
      default: strb = '0;
    endcase
  end

  // R6: at most one strobe; an unused code raises none
  always_comb begin
    if (!$isunknown(opCode)) begin
      a_r6_strobe_onehot: assert ($onehot0(strb));
      a_r6_unused_quiet: assert (!(opCode[2] && opCode[1]) || (strb == '0));
    end
  end

endmodule

// File: rtl/alu16_dp.sv
module alu16_dp
  import alu16_pkg::*;
#(
  parameter int dataW = 16
) (
  input  logic [dataW-1:0] opA,
  input  logic [dataW-1:0] opB,
  input  aluStrobe_t       strb,
  output logic [dataW-1:0] result,
  output logic             isZero
);

  localparam int SelW = $clog2(dataW);

  // shared adder: add, subtract and the compare all use one carry chain
  logic             invB;
  logic [dataW-1:0] bOperand;
  logic [dataW:0]   sumExt;
  logic             aBelowB;

  assign invB     = strb.doSub | strb.doSlt;
  assign bOperand = opB ^ {dataW{invB}};
  assign sumExt   = {1'b0, opA} + {1'b0, bOperand} + {{dataW{1'b0}}, invB};
  // no carry out of a + ~b + 1 means a borrow, i.e. opA < opB unsigned
  assign aBelowB  = ~sumExt[dataW];

  // one-hot decode of the low index bits of opA
  logic [SelW-1:0]  decIdx;
  logic [dataW-1:0] decWord;

  assign decIdx = opA[SelW-1:0];

  for (genvar i = 0; i < dataW; i++) begin : g_dec
    assign decWord[i] = (decIdx == SelW'(i));
  end

  always_comb begin
    result = '0;
    if (strb.doAdd | strb.doSub) result = sumExt[dataW-1:0];
    if (strb.doAnd)              result = opA & opB;
    if (strb.doOr)               result = opA | opB;
    if (strb.doDec)              result = decWord;
    if (strb.doSlt)              result = {{(dataW-1){1'b0}}, aBelowB};
  end

  assign isZero = ~|result;

  // R4: the decode word always carries exactly one set bit
  always_comb begin
    if (!$isunknown(opA)) begin
      a_r4_dec_word_onehot: assert ($onehot(decWord));
    end
  end

endmodule

// File: rtl/alu16.sv
module alu16
  import alu16_pkg::*;
#(
  parameter int dataW = 16
) (
  input  logic [dataW-1:0]   opA,
  input  logic [dataW-1:0]   opB,
  input  logic [OpCodeW-1:0] opCode,
  output logic [dataW-1:0]   result,
  output logic               isZero
);

  aluStrobe_t strb;

  alu16_ctrl u_ctrl (
    .opCode (opCode),
    .strb   (strb)
  );

  alu16_dp #(.dataW(dataW)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .strb   (strb),
    .result (result),
    .isZero (isZero)
  );

  always_comb begin
    if (!$isunknown({opA, opB, opCode})) begin
      // R5: compare yields exactly the unsigned ordering, as 0 or 1
      a_r5_slt_binary: assert ((opCode != OpSlt) ||
                               (result == {{(dataW-1){1'b0}}, (opA < opB)}));
      // R4: decode output is one-hot at the port
      a_r4_decode_onehot: assert ((opCode != OpDec) || $onehot(result));
      // R8: subtracting equal operands raises the zero flag
      a_r8_equal_sub: assert ((opCode != OpSub) || ((opA == opB) == isZero));
      // R6: unused codes drive a zero result and raise the flag
      a_r6_unused_zero: assert (!(opCode[2] && opCode[1]) || (isZero && result == '0));
      // R7: flag and result agree
      a_r7_zero_flag: assert (isZero == (result == '0));
    end
  end

endmodule

// File: tb/sim_alu16.sv
`timescale 1ns/1ps
module sim_alu16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] aW, bW, resW;
  logic [3:0]  aN, bN, resN;
  logic [2:0]  codeW, codeN;
  logic        zW, zN;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  alu16 u0 (.opA(aW), .opB(bW), .opCode(codeW), .result(resW), .isZero(zW));
  alu16 #(.dataW(4)) u1 (.opA(aN), .opB(bN), .opCode(codeN), .result(resN), .isZero(zN));

  function automatic int refAlu(input int w, input int op, input int a, input int b);
    int mask = (1 << w) - 1;
    a = a & mask;
    b = b & mask;
    case (op)
      0: return (a + b) & mask;
      1: return (a - b) & mask;
      2: return a & b;
      3: return a | b;
      4: return (1 << (a & (w - 1))) & mask;
      5: return (a < b) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tagOf(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive both instances after a rising edge, sample on the falling edge
  task automatic applyBoth(input int op, input int aw, input int bw, input int an, input int bn);
    int expW, expN;
    @(posedge clk);
    codeW = 3'(op); aW = 16'(aw); bW = 16'(bw);
    codeN = 3'(op); aN = 4'(an);  bN = 4'(bn);
    @(negedge clk);
    expW = refAlu(16, op, aw, bw);
    expN = refAlu(4, op, an, bn);
    checkVal(tagOf(op), int'(resW), expW);
    checkVal("R7", int'(zW), (expW == 0) ? 1 : 0);
    checkVal(tagOf(op), int'(resN), expN);
    checkVal("R7", int'(zN), (expN == 0) ? 1 : 0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int corners[6];
    corners = '{0, 1, 16'hffff, 16'h8000, 16'h7fff, 16'h00f0};
    aW = '0; bW = '0; codeW = '0; aN = '0; bN = '0; codeN = '0;
    @(negedge clk);
    // initial state: add of zero operands gives zero result and flag
    checkVal("R1", int'(resW), 0);
    checkVal("R7", int'(zW), 1);

    // exhaustive sweep on the narrow instance, random wide operands alongside
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          applyBoth(op, int'($urandom() & 16'hffff), int'($urandom() & 16'hffff), a, b);

    // directed wide corners
    for (int op = 0; op < 8; op++)
      foreach (corners[i])
        foreach (corners[j])
          applyBoth(op, corners[i], corners[j], corners[i] & 15, corners[j] & 15);

    // every decode index at full width, with opB varied (R4)
    for (int k = 0; k < 16; k++)
      applyBoth(4, k | 16'h5a50, 16'(k * 4099), k & 3, 15 - k);

    // equality branch subtract (R8)
    for (int k = 0; k < 64; k++) begin
      int v = int'($urandom() & 16'hffff);
      applyBoth(1, v, v, v & 15, v & 15);
      checkVal("R8", int'(zW), 1);
      applyBoth(1, v, v ^ (1 << (k % 16)), 3, 7);
      checkVal("R8", int'(zW), 0);
    end

    // unused codes with nonzero operands (R6)
    applyBoth(6, 16'hffff, 16'hffff, 15, 15);
    checkVal("R6", int'(resW), 0);
    applyBoth(7, 16'h1234, 16'h8001, 9, 2);
    checkVal("R6", int'(resN), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule